// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Display Driver

This block shows a 16-bit word of four BCD digits, plus one decimal point per digit, on a four-digit common-anode seven-segment display. It lights one digit at a time: a scan state machine steps through the four digit positions. In each position it pulls that digit's common line low, routes that digit's nibble through a segment decoder and drives that digit's decimal point. Scanning faster than the eye can follow makes all four digits appear lit together.

The scan rate comes from a free-running prescaler on the board clock. The prescaler is built from a low counter and a high counter, and the high counter advances each time the low one wraps. A 2-bit run-time rate select picks one of four prescaler taps, so a fast, flicker-free scan and progressively slower, visibly stepping scans can be compared. The whole block runs on the single board clock. The state machine advances on a one-cycle step pulse that is produced when the selected tap rises.

The state machine has four states, SCAN_D0, SCAN_D1, SCAN_D2 and SCAN_D3. Its transitions are ADVANCE (SCAN_Dn to SCAN_Dn+1 on a step pulse), WRAP (SCAN_D3 to SCAN_D0 on a step pulse), HOLD (no step pulse, same state) and RESET (any state to SCAN_D0).

Top module: `mux_disp_drv`

## Requirements
- R1: A synchronous active-high `rst` puts the scan in SCAN_D0 and clears the prescaler. While `rst` is held and in the cycle after it is released, `dig_en_n` is 4'b1110.
- R2: The prescaler counts once per clock from zero after reset. It is made of a LO_W-bit low counter and a HI_W-bit high counter, and the high counter increments exactly in the cycles where the low counter wraps from all ones.
- R3: `rate_sel` value 0, 1, 2 or 3 chooses prescaler bit TAP0, TAP1, TAP2 or TAP3 (defaults 17, 19, 21, 23; code 0 is fastest). After a reset with `rate_sel` = k, the first digit change follows the clock edge numbered 2^TAPk + 1.
- R4: `rate_sel` is captured in a register, so a change affects tap selection one clock later.
- R5: The scan advances one state per rising edge of the selected tap, as seen one cycle late (tap bit 1 now and 0 in the previous cycle). The order is SCAN_D0, SCAN_D1, SCAN_D2, SCAN_D3, then back to SCAN_D0. Without a step the state holds.
- R6: In state SCAN_Dn, bit n of `dig_en_n` is 0 and the other three bits are 1.
- R7: In state SCAN_Dn, the decoded nibble is `bcd_word[4n+3:4n]`.
- R8: In state SCAN_Dn, `dp_n` equals the inverse of `dp_in[n]`.
- R9: `seg_n[6:0]` is active low in the order g,f,e,d,c,b,a (bit 0 is segment a). Digits 0 to 9 use the usual seven-segment patterns, with segments lit as follows: 0 = a,b,c,d,e,f; 1 = b,c; 2 = a,b,d,e,g; 3 = a,b,c,d,g; 4 = b,c,f,g; 5 = a,c,d,f,g; 6 = a,c,d,e,f,g; 7 = a,b,c; 8 = all; 9 = a,b,c,d,f,g. Nibbles 10 to 15 give 7'b1111111.
- R10: `seg_n` and `dp_n` follow changes of `bcd_word` and `dp_in` within the same clock cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Scan rate select (prescaler tap choice) |
| bcd_word | input | 16 | Four BCD digits, digit 0 in bits 3:0 |
| dp_in | input | 4 | Decimal point request per digit, active high |
| seg_n | output | 7 | Segment drives g..a, active low |
| dp_n | output | 1 | Decimal point drive, active low |
| dig_en_n | output | 4 | Digit common enables, active low |

## Verification
A wrong scan state appears at once on `dig_en_n` as the wrong digit low, or as more or fewer than one digit low. It also appears on `seg_n` and `dp_n` as a neighbouring digit's content in that same cycle. A prescaler or tap fault cannot be seen directly. It shows only in timing: the digit changes early or late against a cycle-exact model of the counter, and the error appears at the first step pulse. With reduced tap positions that is within a few dozen cycles. Select-register faults show as a step that occurs one cycle away from its expected place just after `rate_sel` changes.

// File: rtl/mux_disp_pkg.sv
package mux_disp_pkg;

    localparam int unsigned DIGITS = 4;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned SEG_W  = 7;
    localparam int unsigned SCAN_W = $clog2(DIGITS);

    typedef enum logic [SCAN_W-1:0] {
        SCAN_D0 = 2'd0,
        SCAN_D1 = 2'd1,
        SCAN_D2 = 2'd2,
        SCAN_D3 = 2'd3
    } scan_state_e;

endpackage

// File: rtl/disp_prescaler.sv
module disp_prescaler #(
    parameter int unsigned LO_W = 16,
    parameter int unsigned HI_W = 8,
    localparam int unsigned PRE_W = LO_W + HI_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PRE_W-1:0] count
);

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            lo_wrap;

    assign lo_wrap = &lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_q + 1'b1;
            if (lo_wrap) begin
                hi_q <= hi_q + 1'b1;
            end
        end
    end

    assign count = {hi_q, lo_q};

    // R2: high half moves only when low half wraps
    p_carry_r2: assert property (@(posedge clk) disable iff (rst)
        lo_wrap |=> (hi_q == $past(hi_q) + 1'b1));
    p_hold_hi_r2: assert property (@(posedge clk) disable iff (rst)
        !lo_wrap |=> $stable(hi_q));
    // R1: reset clears the prescaler
    p_clear_r1: assert property (@(posedge clk)
        rst |=> (count == '0));

endmodule

// File: rtl/disp_rate_sel.sv
module disp_rate_sel #(
    parameter int unsigned PRE_W = 24,
    parameter int unsigned TAP0  = 17,
    parameter int unsigned TAP1  = 19,
    parameter int unsigned TAP2  = 21,
    parameter int unsigned TAP3  = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       rate_sel,
    input  logic [PRE_W-1:0] count,
    output logic             step
);

    logic [1:0] sel_q;
    logic       tap_now;
    logic       tap_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 2'd0;
            tap_prev <= 1'b0;
        end else begin
            sel_q    <= rate_sel;
            tap_prev <= tap_now;
        end
    end

    always_comb begin
        unique case (sel_q)
            2'd0:    tap_now = count[TAP0];
            2'd1:    tap_now = count[TAP1];
            2'd2:    tap_now = count[TAP2];
            default: tap_now = count[TAP3];
        endcase
    end

    assign step = tap_now & ~tap_prev;

    // R5: a step is a single-cycle pulse
    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
    // R4: the tap choice lags the select input by one cycle
    p_sel_lag_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rate_sel) |=> (sel_q == $past(rate_sel)));

endmodule

// File: rtl/disp_scan_fsm.sv
module disp_scan_fsm
    import mux_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output scan_state_e       state,
    output logic [DIGITS-1:0] dig_en_n
);

    scan_state_e state_q;
    scan_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_D0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                SCAN_D0: state_d = SCAN_D1;
                SCAN_D1: state_d = SCAN_D2;
                SCAN_D2: state_d = SCAN_D3;
                SCAN_D3: state_d = SCAN_D0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SCAN_D0: dig_en_n = 4'b1110;
            SCAN_D1: dig_en_n = 4'b1101;
            SCAN_D2: dig_en_n = 4'b1011;
            SCAN_D3: dig_en_n = 4'b0111;
        endcase
    end

    assign state = state_q;

    // R5: hold without a step, wrap after the last digit
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && state_q == SCAN_D3) |=> (state_q == SCAN_D0));
    // R6: exactly one enable low
    p_one_low_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(dig_en_n) == 3);

endmodule

// File: rtl/disp_seg_decode.sv
module disp_seg_decode
    import mux_disp_pkg::*;
(
    input  logic [NIB_W-1:0] nibble,
    output logic [SEG_W-1:0] seg_n
);

    logic [SEG_W-1:0] seg_on;

    always_comb begin
        unique case (nibble)
            4'd0:    seg_on = 7'b0111111;
            4'd1:    seg_on = 7'b0000110;
            4'd2:    seg_on = 7'b1011011;
            4'd3:    seg_on = 7'b1001111;
            4'd4:    seg_on = 7'b1100110;
            4'd5:    seg_on = 7'b1101101;
            4'd6:    seg_on = 7'b1111101;
            4'd7:    seg_on = 7'b0000111;
            4'd8:    seg_on = 7'b1111111;
            4'd9:    seg_on = 7'b1101111;
            default: seg_on = 7'b0000000;
        endcase
    end

    assign seg_n = ~seg_on;

endmodule

// File: rtl/mux_disp_drv.sv
module mux_disp_drv
    import mux_disp_pkg::*;
#(
    parameter int unsigned LO_W = 16,
    parameter int unsigned HI_W = 8,
    parameter int unsigned TAP0 = 17,
    parameter int unsigned TAP1 = 19,
    parameter int unsigned TAP2 = 21,
    parameter int unsigned TAP3 = 23
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  rate_sel,
    input  logic [15:0] bcd_word,
    input  logic [3:0]  dp_in,
    output logic [6:0]  seg_n,
    output logic        dp_n,
    output logic [3:0]  dig_en_n
);

    localparam int unsigned PRE_W = LO_W + HI_W;

    logic [PRE_W-1:0] count;
    logic             step;
    scan_state_e      state;
    logic [NIB_W-1:0] nibble;
    logic             dp_sel;

    disp_prescaler #(.LO_W(LO_W), .HI_W(HI_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    disp_rate_sel #(
        .PRE_W(PRE_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_rate (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .count    (count),
        .step     (step)
    );

    disp_scan_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .state    (state),
        .dig_en_n (dig_en_n)
    );

    always_comb begin
        unique case (state)
            SCAN_D0: begin nibble = bcd_word[3:0];   dp_sel = dp_in[0]; end
            SCAN_D1: begin nibble = bcd_word[7:4];   dp_sel = dp_in[1]; end
            SCAN_D2: begin nibble = bcd_word[11:8];  dp_sel = dp_in[2]; end
            SCAN_D3: begin nibble = bcd_word[15:12]; dp_sel = dp_in[3]; end
        endcase
    end

    assign dp_n = ~dp_sel;

    disp_seg_decode u_dec (
        .nibble (nibble),
        .seg_n  (seg_n)
    );

    // R1: reset shows digit 0
    p_reset_digit0_r1: assert property (@(posedge clk)
        rst |=> (dig_en_n == 4'b1110));
    // R8: decimal point of the enabled digit
    p_dp_digit3_r8: assert property (@(posedge clk) disable iff (rst)
        (dig_en_n == 4'b0111) |-> (dp_n == !dp_in[3]));
    // R9: non-decimal nibbles blank the digit
    p_blank_r9: assert property (@(posedge clk) disable iff (rst)
        (nibble > 4'd9) |-> (seg_n == 7'b1111111));

endmodule

// File: tb/test_mux_disp_drv.sv
module test_mux_disp_drv;

    localparam int LO_W = 3;
    localparam int HI_W = 3;
    localparam int T0 = 1;
    localparam int T1 = 2;
    localparam int T2 = 3;
    localparam int T3 = 4;
    localparam int NVEC = 6;

    // vector: [31:22] cycles, [21:20] rate, [19:16] dp, [15:0] bcd
    localparam logic [31:0] VECS [NVEC] = '{
        {10'd40,  2'd0, 4'b0001, 16'h1234},
        {10'd60,  2'd1, 4'b1010, 16'h5678},
        {10'd100, 2'd2, 4'b0100, 16'h9012},
        {10'd260, 2'd3, 4'b1111, 16'hFEDC},
        {10'd50,  2'd0, 4'b0000, 16'hA9B3},
        {10'd200, 2'd3, 4'b0110, 16'h7465}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rate_sel = 2'd0;
    logic [15:0] bcd_word = 16'h0000;
    logic [3:0]  dp_in = 4'b0000;
    logic [6:0]  seg_n;
    logic        dp_n;
    logic [3:0]  dig_en_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mux_disp_drv #(
        .LO_W(LO_W), .HI_W(HI_W), .TAP0(T0), .TAP1(T1), .TAP2(T2), .TAP3(T3)
    ) i_mux_disp_drv (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .bcd_word(bcd_word),
        .dp_in(dp_in), .seg_n(seg_n), .dp_n(dp_n), .dig_en_n(dig_en_n)
    );

    // reference model built from the requirements
    logic [LO_W+HI_W-1:0] m_cnt = '0;
    logic [1:0]           m_sel = 2'd0;
    logic                 m_prev = 1'b0;
    logic [1:0]           m_scan = 2'd0;

    function automatic int tap_of(logic [1:0] s);
        case (s)
            2'd0:    return T0;
            2'd1:    return T1;
            2'd2:    return T2;
            default: return T3;
        endcase
    endfunction

    function automatic logic [6:0] seg_ref(logic [3:0] v);
        logic [6:0] lit;
        case (v)
            4'd0: lit = 7'h3F; 4'd1: lit = 7'h06; 4'd2: lit = 7'h5B;
            4'd3: lit = 7'h4F; 4'd4: lit = 7'h66; 4'd5: lit = 7'h6D;
            4'd6: lit = 7'h7D; 4'd7: lit = 7'h07; 4'd8: lit = 7'h7F;
            4'd9: lit = 7'h6F; default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  <= '0;
            m_sel  <= 2'd0;
            m_prev <= 1'b0;
            m_scan <= 2'd0;
        end else begin
            m_cnt  <= m_cnt + 1'b1;
            m_sel  <= rate_sel;
            m_prev <= m_cnt[tap_of(m_sel)];
            if (m_cnt[tap_of(m_sel)] && !m_prev) m_scan <= m_scan + 1'b1;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_model();
        chk("R4 R5 R6 dig_en_n", {4'h0, dig_en_n}, {4'h0, ~(4'b0001 << m_scan)});
        chk("R7 R9 seg_n", {1'b0, seg_n}, {1'b0, seg_ref(bcd_word[4*m_scan +: 4])});
        chk("R8 dp_n", {7'h0, dp_n}, {7'h0, ~dp_in[m_scan]});
    endtask

    task automatic show_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog: actual hung expected finish");
            show_summary();
            $finish;
        end
    end

    initial begin
        int edges;
        logic [3:0] first_en;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset enable", {4'h0, dig_en_n}, 8'h0E);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {4'h0, dig_en_n}, 8'h0E);

        // table walk; R2 covered by taps T2/T3 that reach the high counter
        for (int v = 0; v < NVEC; v++) begin
            bcd_word = VECS[v][15:0];
            dp_in    = VECS[v][19:16];
            rate_sel = VECS[v][21:20];
            for (int c = 0; c < int'(VECS[v][31:22]); c++) begin
                @(negedge clk);
                chk_model();
            end
        end

        // R3 R2: first step delay from reset with the slowest tap in the high counter
        for (int k = 2; k < 4; k++) begin
            rate_sel = 2'(k);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            edges = 0;
            first_en = dig_en_n;
            while (dig_en_n == first_en && edges < 200) begin
                @(negedge clk);
                edges++;
            end
            chk("R3 R2 first step edge", 8'(edges), 8'((1 << tap_of(2'(k))) + 1));
        end

        // R1: reset in the middle of a scan
        rate_sel = 2'd0;
        repeat (13) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-run reset", {4'h0, dig_en_n}, 8'h0E);

        // R10: same-cycle response to data changes, digit 0 shown
        bcd_word = 16'h0007;
        dp_in    = 4'b0001;
        #1;
        chk("R10 seg follows", {1'b0, seg_n}, {1'b0, seg_ref(4'd7)});
        chk("R10 dp follows", {7'h0, dp_n}, 8'h00);
        bcd_word = 16'h000B;
        dp_in    = 4'b0000;
        #1;
        chk("R9 R10 blank", {1'b0, seg_n}, 8'h7F);
        chk("R10 dp off", {7'h0, dp_n}, 8'h01);

        // R4: change select and follow the model cycle by cycle
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (c % 7 == 3) rate_sel = rate_sel + 2'd1;
            chk_model();
        end

        done = 1'b1;
        show_summary();
        $finish;
    end

endmodule